// File: doc/BRIEF.md
# Double-Precision to Unsigned Integer Converter

This block takes one IEEE 754 binary64 operand and turns it into an unsigned integer, either 32 or 64 bits wide. The value is rounded in one of four modes. A per-operation override can replace the global mode. The block raises an invalid flag when the rounded value has no unsigned representation at the chosen width, and an inexact flag when rounding discarded a nonzero fraction.

A 64-bit result comes out only when the wide mode is permitted and the caller also requests 64 bits. Every other combination gives a 32-bit result, zero-extended onto the 64-bit output bus. An invalid input either saturates to all ones for the width, or, if the invalid exception is unmasked, raises an exception strobe and withholds the result-valid strobe.

The conversion takes one register stage. Its results appear on the clock edge that follows the input strobe.

Top module: `f64_to_uint_cvt`

## Requirements
- R1: Outputs are registered. `out_valid` or `out_exc` (exactly one of them) is high in the cycle after a cycle with `in_valid` high, and both are low after a cycle with `in_valid` low.
- R2: The width is 64 bits only when `wide_en` and `req_w64` are both 1. Otherwise it is 32 bits.
- R3: When `ovr_en` is 1 the rounding mode is `ovr_rm`. Otherwise it is `glob_rm`.
- R4: Mode codes are 00 = nearest, ties to even; 01 = toward minus infinity; 10 = toward plus infinity; 11 = toward zero. A discarded nonzero fraction sets `out_inexact`.
- R5: A rounded value of 2^w or more is invalid. When `inv_mask` is 1, the result is 2^w−1: all 64 bits set for width 64, and bits 31:0 set for width 32.
- R6: A 32-bit result always has bits 63:32 equal to zero.
- R7: Exponent field all ones (NaN of any kind, or infinity of either sign) is invalid.
- R8: A negative input whose rounded magnitude is zero gives 0, without invalid, and with inexact if the input was nonzero. A negative input that rounds to a nonzero magnitude is invalid.
- R9: Zero of either sign and denormals (exponent field 0) give 0 in every mode. Denormals set inexact. Inexact is never set together with invalid.
- R10: An invalid input with `inv_mask` 0 gives `out_exc` 1, `out_invalid` 1, `out_valid` 0, `out_inexact` 0 and a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | binary64 operand |
| wide_en | input | 1 | 64-bit results permitted |
| req_w64 | input | 1 | Request for a 64-bit result |
| glob_rm | input | 2 | Global rounding mode |
| ovr_en | input | 1 | Use the per-operation rounding mode |
| ovr_rm | input | 2 | Per-operation rounding mode |
| inv_mask | input | 1 | Invalid exception masked |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Unsigned result |
| out_invalid | output | 1 | Invalid flag |
| out_inexact | output | 1 | Inexact flag |
| out_exc | output | 1 | Unmasked invalid exception |

## Verification
The hardest cases to reach are the exact limits of representability. One is a value just below 2^32 or 2^64 that rounds up across the limit in one mode and stays below it in another. Another is a negative value under 1 that is valid except when the mode rounds it away from zero. The sweep reaches both by pairing exponents placed around 1.0, 2^32, 2^53 and 2^64 with fractions of all ones, exact half and half plus one ulp. Every such operand is applied under all four modes, both signs and every width-control combination.

// File: rtl/f64_to_uint_cvt.sv
module f64_to_uint_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_op,
  input  logic        wide_en,
  input  logic        req_w64,
  input  logic [1:0]  glob_rm,
  input  logic        ovr_en,
  input  logic [1:0]  ovr_rm,
  input  logic        inv_mask,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic        out_invalid,
  output logic        out_inexact,
  output logic        out_exc
);
  localparam logic [10:0] BIAS_INT = 11'd1075;
  localparam logic [10:0] MAX_EXP  = 11'd1086;

  logic        sgn, w64, is_spec, is_sub, right, huge, g, st, inc, ovf, bad, inx;
  logic [10:0] ex;
  logic [51:0] fr;
  logic [52:0] mant, ip;
  logic [1:0]  rm;
  logic [5:0]  kc, lsh;
  logic [106:0] t;
  logic [63:0] rmag, lmag, mag, sat, res_d;
  logic        exc_d, w_q;

  assign sgn  = in_op[63];
  assign ex   = in_op[62:52];
  assign fr   = in_op[51:0];
  assign w64  = wide_en & req_w64;
  assign rm   = ovr_en ? ovr_rm : glob_rm;
  assign is_spec = &ex;
  assign is_sub  = (ex == 11'd0);
  assign mant = {1'b1, fr};

  assign right = ex < BIAS_INT;
  assign huge  = ex > MAX_EXP;
  assign kc    = (ex <= 11'd1021) ? 6'd54 : 6'(BIAS_INT - ex);
  assign t     = {mant, 54'b0} >> kc;
  assign ip    = t[106:54];
  assign g     = t[53];
  assign st    = |t[52:0];

  always_comb begin
    case (rm)
      2'b00:   inc = g & (st | ip[0]);
      2'b01:   inc = sgn & (g | st);
      2'b10:   inc = ~sgn & (g | st);
      default: inc = 1'b0;
    endcase
  end

  assign rmag = {11'b0, ip} + {63'b0, inc};
  assign lsh  = huge ? 6'd0 : 6'(ex - BIAS_INT);
  assign lmag = {11'b0, mant} << lsh;
  assign mag  = right ? rmag : lmag;

  assign ovf = ~right & huge | (~w64 & (|mag[63:32]));
  assign bad = is_spec | (~is_sub & (ovf | (sgn & (mag != 64'd0))));
  assign inx = ~bad & (is_sub ? (fr != 52'd0) : (right & (g | st)));
  assign sat = w64 ? {64{1'b1}} : {32'b0, {32{1'b1}}};

  always_comb begin
    if (bad)
      res_d = inv_mask ? sat : 64'd0;
    else if (is_sub | sgn)
      res_d = 64'd0;
    else
      res_d = w64 ? mag : {32'b0, mag[31:0]};
  end

  assign exc_d = in_valid & bad & ~inv_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_exc     <= 1'b0;
      out_result  <= 64'd0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      w_q         <= 1'b0;
    end else begin
      out_valid   <= in_valid & ~exc_d;
      out_exc     <= exc_d;
      out_result  <= in_valid ? res_d : 64'd0;
      out_invalid <= in_valid & bad;
      out_inexact <= in_valid & inx;
      w_q         <= w64;
    end
  end

  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid ^ out_exc));
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_exc));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !w_q) |-> (out_result[63:32] == 32'd0));
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_result == (w_q ? {64{1'b1}} : {32'b0, {32{1'b1}}})));
  a_r7_special: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(&in_op[62:52])) |-> out_invalid);
  a_r9_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_invalid && out_inexact));
  a_r10_exc: assert property (@(posedge clk) disable iff (!rst_n)
    out_exc |-> (out_invalid && !out_valid && !out_inexact && out_result == 64'd0));
endmodule

// File: tb/f64_to_uint_cvt_test.sv
module f64_to_uint_cvt_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [63:0] in_op = 64'd0;
  logic wide_en = 1'b0, req_w64 = 1'b0, ovr_en = 1'b0, inv_mask = 1'b1;
  logic [1:0] glob_rm = 2'd0, ovr_rm = 2'd0;
  logic out_valid, out_invalid, out_inexact, out_exc;
  logic [63:0] out_result;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  f64_to_uint_cvt uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .wide_en(wide_en), .req_w64(req_w64), .glob_rm(glob_rm), .ovr_en(ovr_en),
    .ovr_rm(ovr_rm), .inv_mask(inv_mask), .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_inexact(out_inexact), .out_exc(out_exc));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h op=%h", tag, act, exp, in_op);
    end
  endtask

  task automatic model(input logic [63:0] op, input bit w64, input logic [1:0] rm,
                       input bit mask, output logic [63:0] r, output bit inv,
                       output bit inx, output bit exc, output bit vld);
    bit s, big, g, st, up;
    int e;
    logic [63:0] m;
    s = op[63]; e = int'(op[62:52]); big = 0; g = 0; st = 0; up = 0; m = 64'd0;
    inv = 0; inx = 0;
    if (e == 2047) inv = 1;
    else if (e == 0) inx = (op[51:0] != 0);
    else begin
      m = {11'b0, 1'b1, op[51:0]};
      if (e >= 1075)
        for (int i = 0; i < e - 1075; i++) begin if (m[63]) big = 1; m = m << 1; end
      else
        for (int i = 0; i < 1075 - e; i++) begin st = st | g; g = m[0]; m = m >> 1; end
      case (rm)
        2'd0: up = g && (st || m[0]);
        2'd1: up = s && (g || st);
        2'd2: up = !s && (g || st);
        default: up = 0;
      endcase
      m = m + 64'(up);
      if (w64 ? big : (big || (m >> 32) != 0)) inv = 1;
      if (s && m != 0) inv = 1;
      inx = !inv && (g || st);
    end
    exc = inv && !mask;
    vld = !exc;
    if (inv) r = mask ? (w64 ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF) : 64'd0;
    else if (s || e == 0) r = 64'd0;
    else r = w64 ? m : {32'b0, m[31:0]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int exps[26] = '{0, 1, 1020, 1021, 1022, 1023, 1024, 1030, 1053, 1054, 1055, 1056,
                     1073, 1074, 1075, 1076, 1085, 1086, 1087, 1088, 1100, 2046, 2047,
                     1050, 1040, 1062};
    logic [51:0] fracs[6] = '{52'd0, 52'd1, {52{1'b1}}, 52'h8_0000_0000_0000,
                              52'h8_0000_0000_0001, 52'h5_A3C9_1E07_B26D};
    logic [63:0] er;
    bit ei, ex, ee, ev;
    int n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'b0, out_valid}, 64'd0);
    chk("R1 reset exc", {63'b0, out_exc}, 64'd0);
    chk("R1 reset result", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int ie = 0; ie < 26; ie++)
      for (int jf = 0; jf < 6; jf++)
        for (int sg = 0; sg < 2; sg++)
          for (int md = 0; md < 4; md++)
            for (int wc = 0; wc < 4; wc++) begin
              n++;
              in_op = {sg[0], exps[ie][10:0], fracs[jf]};
              wide_en = wc[1]; req_w64 = wc[0];
              ovr_en = n[0];
              if (ovr_en) begin ovr_rm = md[1:0]; glob_rm = ~md[1:0]; end
              else begin glob_rm = md[1:0]; ovr_rm = ~md[1:0]; end
              inv_mask = (n % 3) != 0;
              in_valid = 1'b1;
              model(in_op, wc[1] & wc[0], md[1:0], inv_mask, er, ei, ex, ee, ev);
              @(negedge clk);
              chk("R2/R3/R4/R5/R6/R8/R9 result", out_result, er);
              chk("R5/R7/R8 invalid", {63'b0, out_invalid}, {63'b0, ei});
              chk("R4/R9 inexact", {63'b0, out_inexact}, {63'b0, ex});
              chk("R10 exc", {63'b0, out_exc}, {63'b0, ee});
              chk("R1 valid", {63'b0, out_valid}, {63'b0, ev});
            end
    in_valid = 1'b0;
    in_op = 64'h7FF0_0000_0000_0000;
    @(negedge clk);
    chk("R1 idle valid", {63'b0, out_valid}, 64'd0);
    chk("R1 idle exc", {63'b0, out_exc}, 64'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule